// File: doc/BRIEF.md
# Serial Flash Command Decoder

This block is the slave-side front end of a serial flash memory. While chip select is low it shifts in an 8-bit opcode and then any address, dummy and data bytes, all MSB first. It classifies the opcode and counts bits so it knows whether the frame ended on a byte boundary. The serial pins are oversampled in the system clock domain through a two-stage synchronizer. All frame logic runs on the detected serial clock edges.

Some opcodes return data. For these the block fetches bytes from a synchronous memory-side port and shifts them out on falling serial clock edges. Status and identification bytes come straight from input buses. Write-type commands stream each data byte to the array side as it arrives, with its page-wrapped address. When chip select rises, the block either commits the command with a one-cycle strobe carrying the opcode, the address and the byte count, or rejects it with a one-cycle reject strobe. While the busy input is high, array-access opcodes are ignored for the whole frame.

The serial clock must stay high and low for at least six system clock periods each. The memory port returns data one cycle after a request.

Top module: `sfd_top`

## Requirements
- R1: Opcode and address bits are taken on rising serial clock edges while chip select is low, MSB first; a committed command reports the 24-bit address formed by the three bytes after the opcode, first byte in bits 23:16.
- R2: Recognised opcodes fall into these groups. Single-byte write-type: 06h, 04h, B9h, ABh. Erase: D8h, DBh, each with 3 address bytes. Program: 02h, 0Ah, each with 3 address bytes and then data. Read: 03h with 3 address bytes. Fast read: 0Bh with 3 address bytes and 1 dummy byte. Status: 05h. Identification: 9Fh. A commit strobe carries the received opcode on cmd_opcode_o.
- R3: A write-type frame commits (cmd_valid_o pulses) only if chip select rises after a whole number of bytes and the frame holds at least its minimum: 1 byte for single-byte commands, 4 for erase, 5 for program. Otherwise cmd_reject_o pulses instead. Neither strobe fires for read-type frames.
- R4: Each program data byte pulses wr_valid_o with wr_data_o. Address bits 23:8 of wr_addr_o equal those of the start address, and bits 7:0 equal the start low byte plus the byte index, modulo 256. cmd_len_o counts data bytes, saturating at 256, and is 0 for non-program commands.
- R5: For 03h, after the third address byte the block requests the byte at that address (rd_req_o, rd_addr_o). It shifts the byte out MSB first, starting on the falling edge after the last address bit. Later bytes come from consecutive addresses.
- R6: For 0Bh, output starts only after one dummy byte that follows the address, with data from the given address.
- R7: For 05h, status_i is shifted out again and again until chip select rises.
- R8: For 9Fh, id_i bits 23:16, 15:8 and 7:0 are returned in that order, followed by 00h bytes.
- R9: A read-type frame may end after any bit; nothing is committed or rejected, and the next frame decodes normally.
- R10: miso_o changes only after falling serial clock edges; miso_oe_o is high exactly while cs_ni is low.
- R11: After an unrecognised opcode, the rest of the frame is ignored: no strobes, no memory requests, miso_o stays 0.
- R12: If busy_i is high when the opcode completes, array-access opcodes (03h, 0Bh, 02h, 0Ah, D8h, DBh) are ignored for that frame. 05h, 9Fh and the single-byte commands still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, idle low |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for miso_o |
| busy_i | input | 1 | Internal array cycle running |
| status_i | input | 8 | Status byte to report |
| id_i | input | 24 | Identification bytes |
| rd_req_o | output | 1 | Memory read request pulse |
| rd_addr_o | output | 24 | Memory read address |
| rd_data_i | input | 8 | Memory read data, one cycle after request |
| wr_valid_o | output | 1 | Program data byte strobe |
| wr_addr_o | output | 24 | Page-wrapped byte address |
| wr_data_o | output | 8 | Program data byte |
| cmd_valid_o | output | 1 | Command commit strobe |
| cmd_reject_o | output | 1 | Command reject strobe |
| cmd_opcode_o | output | 8 | Opcode of the strobed command |
| cmd_addr_o | output | 24 | Address of the strobed command |
| cmd_len_o | output | 9 | Data byte count of the strobed command |

## Verification
The bench targets frames that end a few bits past a byte, or end before the header is complete. A decoder that checks only the bit count or only the byte count would commit these. Program bursts start near the top of a page and run past 256 bytes, which exposes a carry into bit 8 of the address or a length counter that wraps to zero. Reads are cut off mid-byte and followed by a write-enable frame, to catch frame state that leaks from one frame into the next. Busy, dummy-byte and unknown-opcode frames check that no stray memory request, output bit or strobe gets out.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [2:0] {
    CL_NONE, CL_SIMPLE, CL_ERASE, CL_PROG, CL_READ, CL_FAST, CL_STAT, CL_ID
  } cls_e;

  function automatic cls_e classify(input logic [7:0] op);
    case (op)
      8'h06, 8'h04, 8'hB9, 8'hAB: return CL_SIMPLE;
      8'hD8, 8'hDB:               return CL_ERASE;
      8'h02, 8'h0A:               return CL_PROG;
      8'h03:                      return CL_READ;
      8'h0B:                      return CL_FAST;
      8'h05:                      return CL_STAT;
      8'h9F:                      return CL_ID;
      default:                    return CL_NONE;
    endcase
  endfunction

  function automatic logic is_array(input cls_e c);
    return c inside {CL_ERASE, CL_PROG, CL_READ, CL_FAST};
  endfunction

  function automatic logic is_write(input cls_e c);
    return c inside {CL_SIMPLE, CL_ERASE, CL_PROG};
  endfunction
endpackage

// File: rtl/sfd_sync.sv
module sfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic cs_low_o,
  output logic cs_end_o,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);
  // {mosi, cs_n, sck}
  logic [2:0] pipe_q [STAGES];
  logic       sck_d_q, cs_low_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= 3'b010;
      sck_d_q    <= 1'b0;
      cs_low_d_q <= 1'b0;
    end else begin
      pipe_q[0] <= {mosi_i, cs_ni, sck_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      sck_d_q    <= pipe_q[STAGES-1][0];
      cs_low_d_q <= ~pipe_q[STAGES-1][1];
    end
  end

  assign cs_low_o = ~pipe_q[STAGES-1][1];
  assign mosi_o   = pipe_q[STAGES-1][2];
  assign cs_end_o = cs_low_d_q & ~cs_low_o;
  assign rise_o   = cs_low_o & pipe_q[STAGES-1][0] & ~sck_d_q;
  assign fall_o   = cs_low_o & ~pipe_q[STAGES-1][0] & sck_d_q;
endmodule

// File: rtl/sfd_frame.sv
module sfd_frame
  import sfd_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int PAGE_W     = $clog2(PAGE_BYTES),
  localparam int LEN_W      = PAGE_W + 1,
  localparam int CNT_W      = $clog2(ADDR_BYTES + 3) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_low_i,
  input  logic              cs_end_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  input  logic              busy_i,
  output logic              start_o,
  output cls_e              start_cls_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              cmd_valid_o,
  output logic              cmd_reject_o,
  output logic [7:0]        cmd_opcode_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o
);
  localparam logic [CNT_W-1:0] NB_MAX  = '1;
  localparam logic [CNT_W-1:0] NB_ADR  = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] NB_DUMY = CNT_W'(ADDR_BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PAGE_BYTES);

  logic [2:0]        bitpos_q;
  logic [CNT_W-1:0]  nb_q;
  logic [6:0]        sr_q;
  logic [7:0]        op_q;
  cls_e              cls_q;
  logic              ign_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [PAGE_W-1:0] woff_q;

  logic [7:0]        byte_w;
  logic              byte_done;
  logic [ADDR_W-1:0] addr_nxt;
  cls_e              cls_w;
  logic [CNT_W-1:0]  need;

  assign byte_w    = {sr_q, mosi_i};
  assign byte_done = rise_i && (bitpos_q == 3'd7);
  assign addr_nxt  = {addr_q[ADDR_W-9:0], byte_w};
  assign cls_w     = classify(byte_w);

  always_comb begin
    case (cls_q)
      CL_SIMPLE: need = CNT_W'(1);
      CL_ERASE:  need = CNT_W'(ADDR_BYTES + 1);
      CL_PROG:   need = CNT_W'(ADDR_BYTES + 2);
      default:   need = NB_MAX;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bitpos_q <= '0; nb_q <= '0; sr_q <= '0; op_q <= '0; cls_q <= CL_NONE;
      ign_q <= 1'b0; addr_q <= '0; len_q <= '0; woff_q <= '0;
      start_o <= 1'b0; start_cls_o <= CL_NONE; start_addr_o <= '0;
      wr_valid_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      cmd_valid_o <= 1'b0; cmd_reject_o <= 1'b0;
      cmd_opcode_o <= '0; cmd_addr_o <= '0; cmd_len_o <= '0;
    end else begin
      start_o      <= 1'b0;
      wr_valid_o   <= 1'b0;
      cmd_valid_o  <= 1'b0;
      cmd_reject_o <= 1'b0;
      // decision at frame end uses the state before clearing
      if (cs_end_i && nb_q != '0 && !ign_q && is_write(cls_q)) begin
        cmd_opcode_o <= op_q;
        cmd_addr_o   <= addr_q;
        cmd_len_o    <= len_q;
        if (bitpos_q == 3'd0 && nb_q >= need) cmd_valid_o  <= 1'b1;
        else                                  cmd_reject_o <= 1'b1;
      end
      if (!cs_low_i) begin
        bitpos_q <= '0; nb_q <= '0; sr_q <= '0; cls_q <= CL_NONE;
        ign_q <= 1'b0; addr_q <= '0; len_q <= '0; woff_q <= '0;
      end else if (rise_i) begin
        bitpos_q <= bitpos_q + 3'd1;
        sr_q     <= {sr_q[5:0], mosi_i};
        if (byte_done) begin
          if (nb_q != NB_MAX) nb_q <= nb_q + CNT_W'(1);
          if (nb_q == '0) begin
            op_q  <= byte_w;
            cls_q <= cls_w;
            ign_q <= (cls_w == CL_NONE) || (is_array(cls_w) && busy_i);
            if (cls_w == CL_STAT || cls_w == CL_ID) begin
              start_o     <= 1'b1;
              start_cls_o <= cls_w;
            end
          end else if (!ign_q) begin
            if (nb_q <= NB_ADR) begin
              addr_q <= addr_nxt;
              if (nb_q == NB_ADR && cls_q == CL_READ) begin
                start_o      <= 1'b1;
                start_cls_o  <= CL_READ;
                start_addr_o <= addr_nxt;
              end
            end else begin
              if (nb_q == NB_DUMY && cls_q == CL_FAST) begin
                start_o      <= 1'b1;
                start_cls_o  <= CL_FAST;
                start_addr_o <= addr_q;
              end
              if (cls_q == CL_PROG) begin
                wr_valid_o <= 1'b1;
                wr_data_o  <= byte_w;
                wr_addr_o  <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + woff_q};
                woff_q     <= woff_q + PAGE_W'(1);
                if (len_q != LEN_MAX) len_q <= len_q + LEN_W'(1);
              end
            end
          end
        end
      end
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && cmd_reject_o));
  p_commit_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(bitpos_q) == 3'd0);
  p_len_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_len_o <= LEN_MAX);
  p_wr_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  p_cmd_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || cmd_reject_o) |=> !(cmd_valid_o || cmd_reject_o));
endmodule

// File: rtl/sfd_tx.sv
module sfd_tx
  import sfd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ID_BYTES = 3,
  localparam int IDX_W   = $clog2(ID_BYTES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_low_i,
  input  logic                  fall_i,
  input  logic                  start_i,
  input  cls_e                  start_cls_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic [7:0]            status_i,
  input  logic [8*ID_BYTES-1:0] id_i,
  input  logic [7:0]            rd_data_i,
  output logic                  rd_req_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  output logic                  miso_o
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(ID_BYTES);

  logic              act_q, pend_q;
  cls_e              cls_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        nxt_q;
  logic [6:0]        sh_q;
  logic [2:0]        bitc_q;
  logic [7:0]        id_byte, ld_byte;

  always_comb begin
    id_byte = '0;
    for (int k = 0; k < ID_BYTES; k++)
      if (idx_q == IDX_W'(k)) id_byte = id_i[8*(ID_BYTES-1-k) +: 8];
  end

  always_comb begin
    case (cls_q)
      CL_STAT: ld_byte = status_i;
      CL_ID:   ld_byte = id_byte;
      default: ld_byte = nxt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; pend_q <= 1'b0; cls_q <= CL_NONE; ptr_q <= '0; idx_q <= '0;
      nxt_q <= '0; sh_q <= '0; bitc_q <= '0; miso_o <= 1'b0;
      rd_req_o <= 1'b0; rd_addr_o <= '0;
    end else begin
      rd_req_o <= 1'b0;
      pend_q   <= rd_req_o;
      if (pend_q) nxt_q <= rd_data_i;
      if (!cs_low_i) begin
        act_q <= 1'b0; miso_o <= 1'b0; bitc_q <= '0;
      end else if (start_i) begin
        act_q  <= 1'b1;
        cls_q  <= start_cls_i;
        bitc_q <= '0;
        idx_q  <= '0;
        if (start_cls_i == CL_READ || start_cls_i == CL_FAST) begin
          rd_req_o  <= 1'b1;
          rd_addr_o <= start_addr_i;
          ptr_q     <= start_addr_i + ADDR_W'(1);
        end
      end else if (act_q && fall_i) begin
        bitc_q <= bitc_q + 3'd1;
        if (bitc_q == 3'd0) begin
          miso_o <= ld_byte[7];
          sh_q   <= ld_byte[6:0];
          if (cls_q == CL_ID && idx_q != IDX_END) idx_q <= idx_q + IDX_W'(1);
          // prefetch the following byte while this one shifts out
          if (cls_q == CL_READ || cls_q == CL_FAST) begin
            rd_req_o  <= 1'b1;
            rd_addr_o <= ptr_q;
            ptr_q     <= ptr_q + ADDR_W'(1);
          end
        end else begin
          miso_o <= sh_q[6];
          sh_q   <= {sh_q[5:0], 1'b0};
        end
      end
    end
  end

  p_miso_on_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_low_i && !fall_i) |=> $stable(miso_o));
  p_req_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |=> !rd_req_o || $past(start_i));
endmodule

// File: rtl/sfd_top.sv
module sfd_top
  import sfd_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PAGE_BYTES  = 256,
  parameter int ID_BYTES    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  cs_ni,
  input  logic                  mosi_i,
  output logic                  miso_o,
  output logic                  miso_oe_o,
  input  logic                  busy_i,
  input  logic [7:0]            status_i,
  input  logic [8*ID_BYTES-1:0] id_i,
  output logic                  rd_req_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  input  logic [7:0]            rd_data_i,
  output logic                  wr_valid_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [7:0]            wr_data_o,
  output logic                  cmd_valid_o,
  output logic                  cmd_reject_o,
  output logic [7:0]            cmd_opcode_o,
  output logic [ADDR_W-1:0]     cmd_addr_o,
  output logic [LEN_W-1:0]      cmd_len_o
);
  logic              cs_low, cs_end, rise, fall, mosi_s, start;
  cls_e              start_cls;
  logic [ADDR_W-1:0] start_addr;

  sfd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .cs_low_o(cs_low), .cs_end_o(cs_end), .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s)
  );

  sfd_frame #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_frame (
    .clk_i, .rst_ni, .cs_low_i(cs_low), .cs_end_i(cs_end), .rise_i(rise),
    .mosi_i(mosi_s), .busy_i,
    .start_o(start), .start_cls_o(start_cls), .start_addr_o(start_addr),
    .wr_valid_o, .wr_addr_o, .wr_data_o,
    .cmd_valid_o, .cmd_reject_o, .cmd_opcode_o, .cmd_addr_o, .cmd_len_o
  );

  sfd_tx #(.ADDR_W(ADDR_W), .ID_BYTES(ID_BYTES)) i_tx (
    .clk_i, .rst_ni, .cs_low_i(cs_low), .fall_i(fall),
    .start_i(start), .start_cls_i(start_cls), .start_addr_i(start_addr),
    .status_i, .id_i, .rd_data_i, .rd_req_o, .rd_addr_o, .miso_o
  );

  assign miso_oe_o = ~cs_ni;
endmodule

// File: tb/test_sfd_top.sv
module test_sfd_top;
  localparam int H = 8;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [1:0]  nadr;
    logic [3:0]  ndat;
    logic [2:0]  xbits;
    logic        ok;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h06, 24'h000000, 2'd0, 4'd0, 3'd0, 1'b1},
    '{8'h04, 24'h000000, 2'd0, 4'd0, 3'd0, 1'b1},
    '{8'hB9, 24'h000000, 2'd0, 4'd0, 3'd0, 1'b1},
    '{8'hAB, 24'h000000, 2'd0, 4'd0, 3'd0, 1'b1},
    '{8'h06, 24'h000000, 2'd0, 4'd0, 3'd5, 1'b0},
    '{8'hD8, 24'h123456, 2'd3, 4'd0, 3'd0, 1'b1},
    '{8'hDB, 24'h00ABCD, 2'd3, 4'd0, 3'd0, 1'b1},
    '{8'hDB, 24'h00ABCD, 2'd2, 4'd0, 3'd0, 1'b0},
    '{8'hD8, 24'h123456, 2'd3, 4'd0, 3'd3, 1'b0},
    '{8'h02, 24'h401200, 2'd3, 4'd3, 3'd0, 1'b1},
    '{8'h0A, 24'h771000, 2'd3, 4'd2, 3'd0, 1'b1},
    '{8'h02, 24'h771000, 2'd3, 4'd0, 3'd0, 1'b0},
    '{8'h0A, 24'h771000, 2'd3, 4'd2, 3'd6, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic [7:0]  status = 8'hA5;
  logic [23:0] id = 24'hC22015;
  logic [7:0]  rd_data = 8'h00;
  logic        miso, miso_oe, rd_req, wr_valid, cmd_valid, cmd_reject;
  logic [23:0] rd_addr, wr_addr, cmd_addr;
  logic [7:0]  wr_data, cmd_opcode;
  logic [8:0]  cmd_len;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_rej = 0, n_wr = 0, n_req = 0, stab_err = 0;
  logic [7:0]  last_op;
  logic [23:0] last_addr;
  logic [8:0]  last_len;
  logic [23:0] wr_alog [300];
  logic [7:0]  wr_dlog [300];

  always #5 clk = ~clk;

  sfd_top i_sfd_top (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .busy_i(busy), .status_i(status), .id_i(id),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .cmd_valid_o(cmd_valid), .cmd_reject_o(cmd_reject), .cmd_opcode_o(cmd_opcode),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len)
  );

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] dat_f(input int i);
    return 8'(i * 29 + 7);
  endfunction

  always @(posedge clk) begin
    if (rd_req) rd_data <= mem_f(rd_addr);
    if (rst_n) begin
      if (cmd_valid) begin
        n_valid++; last_op = cmd_opcode; last_addr = cmd_addr; last_len = cmd_len;
      end
      if (cmd_reject) n_rej++;
      if (wr_valid) begin
        if (n_wr < 300) begin wr_alog[n_wr] = wr_addr; wr_dlog[n_wr] = wr_data; end
        n_wr++;
      end
      if (rd_req) n_req++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic b, output logic s);
    mosi = b;
    repeat (H) @(posedge clk);
    #1 s = miso; sck = 1'b1;
    repeat (H) @(posedge clk);
    #1 if (miso !== s) stab_err++;
    sck = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], r[i]);
  endtask

  task automatic cs_on();
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (H) @(posedge clk); #1;
  endtask

  task automatic cs_off();
    repeat (H) @(posedge clk); #1 cs_n = 1'b1;
    repeat (16) @(posedge clk); #1;
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xfer_byte(b, r);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic s;
    int v0, r0, w0, q0, bad;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R10 reset oe", miso_oe, 0);
    chk("R10 reset miso", miso, 0);
    chk("R3 reset strobes", {cmd_valid, cmd_reject, wr_valid, rd_req}, 0);

    // table of write-type frames
    for (int vi = 0; vi < NV; vi++) begin
      vec_t v;
      v = VECS[vi];
      v0 = n_valid; r0 = n_rej; w0 = n_wr;
      cs_on();
      chk("R10 oe during frame", miso_oe, 1);
      send(v.op);
      for (int a = 0; a < int'(v.nadr); a++) send(v.addr[8*(2-a) +: 8]);
      for (int d = 0; d < int'(v.ndat); d++) send(dat_f(d));
      for (int x = 0; x < int'(v.xbits); x++) xfer_bit(1'b1, s);
      cs_off();
      if (v.ok) begin
        chk("R3 commit", n_valid - v0, 1);
        chk("R3 no reject", n_rej - r0, 0);
        chk("R2 opcode", last_op, v.op);
        if (v.nadr == 2'd3) chk("R1 address", last_addr, v.addr);
        chk("R4 length", last_len, (v.op == 8'h02 || v.op == 8'h0A) ? v.ndat : 0);
        if (v.op == 8'h02 || v.op == 8'h0A) begin
          chk("R4 byte strobes", n_wr - w0, v.ndat);
          bad = 0;
          for (int d = 0; d < int'(v.ndat); d++)
            if (wr_alog[w0+d] !== v.addr + 24'(d) || wr_dlog[w0+d] !== dat_f(d)) bad++;
          chk("R4 byte content", bad, 0);
        end
      end else begin
        chk("R3 reject", n_rej - r0, 1);
        chk("R3 no commit", n_valid - v0, 0);
      end
    end
    chk("R10 oe after frame", miso_oe, 0);

    // R4 page wrap
    v0 = n_valid; w0 = n_wr;
    cs_on(); send(8'h02); send_addr(24'h3456FE);
    for (int d = 0; d < 4; d++) send(dat_f(d));
    cs_off();
    chk("R4 wrap addr0", wr_alog[w0],   24'h3456FE);
    chk("R4 wrap addr1", wr_alog[w0+1], 24'h3456FF);
    chk("R4 wrap addr2", wr_alog[w0+2], 24'h345600);
    chk("R4 wrap addr3", wr_alog[w0+3], 24'h345601);
    chk("R4 wrap commit", n_valid - v0, 1);

    // R4 length saturation
    v0 = n_valid; w0 = n_wr;
    cs_on(); send(8'h0A); send_addr(24'h00AB00);
    for (int d = 0; d < 258; d++) send(dat_f(d));
    cs_off();
    chk("R4 long commit", n_valid - v0, 1);
    chk("R4 long length", last_len, 256);
    chk("R4 long strobes", n_wr - w0, 258);
    chk("R4 long last addr", wr_alog[w0+257], 24'h00AB01);

    // R5 read with increment, then R9 cut mid-byte
    v0 = n_valid; r0 = n_rej;
    cs_on(); send(8'h03); send_addr(24'h00F0FE);
    xfer_byte(8'h00, r); chk("R5 read byte0", r, mem_f(24'h00F0FE));
    xfer_byte(8'h00, r); chk("R5 read byte1", r, mem_f(24'h00F0FF));
    xfer_byte(8'h00, r); chk("R5 read byte2", r, mem_f(24'h00F100));
    for (int i = 0; i < 3; i++) xfer_bit(1'b0, s);
    cs_off();
    chk("R9 no strobe after cut", (n_valid - v0) + (n_rej - r0), 0);
    cs_on(); send(8'h06); cs_off();
    chk("R9 next frame commits", n_valid - v0, 1);
    chk("R9 next frame opcode", last_op, 8'h06);
    chk("R9 no reject", n_rej - r0, 0);

    // R6 fast read: nothing before dummy, data after
    cs_on(); send(8'h0B); send_addr(24'h000020);
    xfer_byte(8'h00, r); chk("R6 dummy byte idle", r, 0);
    xfer_byte(8'h00, r); chk("R6 fast read data", r, mem_f(24'h000020));
    cs_off();

    // R7 status repeats
    cs_on(); send(8'h05);
    xfer_byte(8'h00, r); chk("R7 status first", r, 8'hA5);
    xfer_byte(8'h00, r); chk("R7 status repeat", r, 8'hA5);
    cs_off();
    status = 8'h3C;
    cs_on(); send(8'h05);
    xfer_byte(8'h00, r); chk("R7 status tracks input", r, 8'h3C);
    cs_off();
    status = 8'hA5;

    // R8 identification
    cs_on(); send(8'h9F);
    xfer_byte(8'h00, r); chk("R8 id byte0", r, 8'hC2);
    xfer_byte(8'h00, r); chk("R8 id byte1", r, 8'h20);
    xfer_byte(8'h00, r); chk("R8 id byte2", r, 8'h15);
    xfer_byte(8'h00, r); chk("R8 id tail", r, 8'h00);
    cs_off();

    // R11 unknown opcode
    v0 = n_valid; r0 = n_rej; w0 = n_wr; q0 = n_req; bad = 0;
    cs_on(); send(8'h55);
    for (int i = 0; i < 4; i++) begin xfer_byte(8'hFF, r); bad += int'(r != 0); end
    cs_off();
    chk("R11 miso quiet", bad, 0);
    chk("R11 no activity", (n_valid - v0) + (n_rej - r0) + (n_wr - w0) + (n_req - q0), 0);

    // R12 busy
    busy = 1'b1;
    v0 = n_valid; r0 = n_rej; w0 = n_wr; q0 = n_req;
    cs_on(); send(8'h03); send_addr(24'h000040);
    xfer_byte(8'h00, r); cs_off();
    chk("R12 read ignored data", r, 0);
    chk("R12 read no request", n_req - q0, 0);
    cs_on(); send(8'h02); send_addr(24'h000040); send(8'h11); cs_off();
    cs_on(); send(8'hD8); send_addr(24'h000040); cs_off();
    chk("R12 program/erase ignored", (n_valid - v0) + (n_rej - r0) + (n_wr - w0), 0);
    cs_on(); send(8'h06); cs_off();
    chk("R12 write enable while busy", n_valid - v0, 1);
    cs_on(); send(8'h05); xfer_byte(8'h00, r); cs_off();
    chk("R12 status while busy", r, 8'hA5);
    busy = 1'b0;

    chk("R10 miso stable across high phase", stab_err, 0);
    summary();
    $finish;
  end
endmodule